// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Byte Queue and Line Break

This block turns a stream of bytes into an asynchronous serial line. The bytes are accepted over a valid/ready push port into a 16-entry queue. A serializer takes them out of the queue in arrival order. Each character is sent as one start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then the stop period. The bit rate comes from an external enable that pulses at sixteen times the bit rate, so each bit lasts sixteen such pulses.

The character format can be changed while the block runs. The serializer captures the format when it takes a byte from the queue, so a character that is already in flight is not affected. A break control forces the line low while the serializer keeps its normal timing. The queue therefore keeps draining during a break. Two plain status outputs serve a DMA engine or an interrupt source: one shows that the queue has room, and one shows that the queue and the serializer are both empty.

Back-pressure rules: a byte is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low exactly when the queue holds 16 bytes. A byte that is offered while `in_ready` is low is not stored, and it has no effect on the queue. The sender may hold `in_valid` high until the byte is accepted.

Top module: `uart_tx_core`

## Requirements
- R1: After reset, and whenever the transmitter is empty and break is off, `txd` is high. Directly after reset the queue count is 0 and `tx_empty`, `fifo_empty`, `in_ready` and `tx_rdy` are all 1.
- R2: A character starts with `txd` low for 16 `baud_tick` pulses. The data bits follow with the least significant bit first, and each bit lasts 16 pulses.
- R3: `cfg_len` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Any unused upper bits of the byte are not sent.
- R4: When `cfg_par_en` is 1, a parity bit lasting 16 pulses follows the data bits. With `cfg_par_odd` = 0 the parity bit makes the count of ones over the data bits and the parity bit even. With `cfg_par_odd` = 1 that count is odd. When `cfg_par_en` is 0, no parity bit is sent.
- R5: The stop period is high. It lasts 16 pulses when `cfg_stop_long` = 0. When `cfg_stop_long` = 1 it lasts 24 pulses for 5-bit characters and 32 pulses for 6-, 7- and 8-bit characters. The character ends on the last pulse of the stop period.
- R6: The queue holds up to 16 bytes and sends them in arrival order. A push while the queue is full is ignored, and `fifo_count` never exceeds 16 and changes by at most one per clock.
- R7: `tx_rdy` and `in_ready` are both high while the queue has at least one free entry, and both are low while it is full.
- R8: `tx_empty` is high only when the queue is empty and no character is in progress. It stays low through the last stop pulse and rises on the clock that consumes that pulse.
- R9: While `cfg_break` is 1, `txd` is low whatever the serializer is doing. The serializer keeps its normal pulse-counted timing during a break, and the queue keeps draining.
- R10: The format inputs are sampled when a byte leaves the queue. Changes to them during a character do not alter that character.
- R11: When the queue holds more bytes, the next start bit follows the previous stop period after one clock, with no baud pulse consumed in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | Enable pulse at 16 times the bit rate |
| cfg_len | input | 2 | Data bit count select (0..3 gives 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | Odd parity when 1, even parity when 0 |
| cfg_stop_long | input | 1 | Long stop period (1.5 bits for 5-bit characters, 2 bits otherwise) |
| cfg_break | input | 1 | Forces the serial line low |
| in_valid | input | 1 | Push request |
| in_data | input | 8 | Byte to push |
| in_ready | output | 1 | Queue can accept a byte |
| txd | output | 1 | Serial line, idle high |
| fifo_count | output | 5 | Number of bytes in the queue |
| fifo_empty | output | 1 | Queue is empty |
| fifo_full | output | 1 | Queue is full |
| tx_empty | output | 1 | Queue and serializer are both empty |
| tx_rdy | output | 1 | Queue has room, for DMA or interrupt use |

## Verification
The bench builds the block with its default queue depth of 16 and sixteen pulses per bit, so the full queue and the exact tick counts are both in reach. It sweeps every combination of length, parity mode and stop length, which is 24 formats. In each one it disturbs the format inputs in the middle of the character and compares `txd` against a waveform it computes itself, one pulse at a time. With the baud pulses held off, the bench fills the queue past capacity, shows that the extra push is dropped, and then drains all 17 characters back-to-back to check their order. A break is applied both while the line is idle and during a whole character.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } tx_state_e;

  // Character format captured per character
  typedef struct packed {
    logic [1:0] len;       // 0..3 -> 5..8 data bits
    logic       par_en;
    logic       par_odd;
    logic       stop_long;
  } tx_fmt_t;

  function automatic logic [7:0] len_mask(input logic [1:0] len);
    return 8'hFF >> (2'd3 - len);
  endfunction

  function automatic logic frame_parity(input logic [7:0] d, input tx_fmt_t f);
    return (^(d & len_mask(f.len))) ^ f.par_odd;
  endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_wr, do_rd;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= bump(wr_ptr);
      if (do_rd) rd_ptr <= bump(rd_ptr);
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          done
);

  logic [CW-1:0] cnt;

  assign done = tick && !hold && (cnt == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (hold)   cnt <= '0;
    else if (done)   cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
  import uart_tx_pkg::*;
#(
  parameter int OSR = 16,
  localparam int TW = $clog2(2 * OSR + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  tx_fmt_t    fmt,
  input  logic       src_valid,
  input  logic [7:0] src_data,
  output logic       src_pop,
  output logic       line_bit,
  output logic       idle
);

  localparam logic [TW-1:0] T_BIT     = TW'(OSR);
  localparam logic [TW-1:0] T_ONEHALF = TW'(OSR + OSR / 2);
  localparam logic [TW-1:0] T_TWO     = TW'(2 * OSR);

  tx_state_e     state;
  logic [7:0]    shreg;
  logic [2:0]    bit_idx;
  logic          par_q;
  tx_fmt_t       fmt_q;
  logic [TW-1:0] limit;
  logic          period_done;
  logic          last_data;

  assign idle      = (state == ST_IDLE);
  assign src_pop   = idle && src_valid;
  assign last_data = (bit_idx == 3'(3'd4 + {1'b0, fmt_q.len}));

  always_comb begin
    limit = T_BIT;
    if (state == ST_STOP && fmt_q.stop_long)
      limit = (fmt_q.len == 2'd0) ? T_ONEHALF : T_TWO;
  end

  uart_tx_bit_timer #(.CW(TW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (idle),
    .tick  (baud_tick),
    .limit (limit),
    .done  (period_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      shreg   <= '0;
      bit_idx <= '0;
      par_q   <= 1'b0;
      fmt_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (src_valid) begin
            state   <= ST_START;
            shreg   <= src_data;
            fmt_q   <= fmt;
            par_q   <= frame_parity(src_data, fmt);
            bit_idx <= '0;
          end
        end
        ST_START: if (period_done) state <= ST_DATA;
        ST_DATA: begin
          if (period_done) begin
            shreg <= shreg >> 1;
            if (last_data) state <= fmt_q.par_en ? ST_PARITY : ST_STOP;
            else           bit_idx <= bit_idx + 1'b1;
          end
        end
        ST_PARITY: if (period_done) state <= ST_STOP;
        ST_STOP:   if (period_done) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_START:  line_bit = 1'b0;
      ST_DATA:   line_bit = shreg[0];
      ST_PARITY: line_bit = par_q;
      default:   line_bit = 1'b1;
    endcase
  end

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int OSR        = 16,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud_tick,
  input  logic [1:0]       cfg_len,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic             cfg_stop_long,
  input  logic             cfg_break,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             txd,
  output logic [CNT_W-1:0] fifo_count,
  output logic             fifo_empty,
  output logic             fifo_full,
  output logic             tx_empty,
  output logic             tx_rdy
);

  tx_fmt_t    fmt;
  logic [7:0] q_data;
  logic       pop;
  logic       line_bit;
  logic       ser_idle;

  assign fmt = '{len: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd,
                 stop_long: cfg_stop_long};

  uart_tx_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (in_valid),
    .wr_data (in_data),
    .rd_en   (pop),
    .rd_data (q_data),
    .count   (fifo_count),
    .full    (fifo_full),
    .empty   (fifo_empty)
  );

  uart_tx_serializer #(.OSR(OSR)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .fmt       (fmt),
    .src_valid (!fifo_empty),
    .src_data  (q_data),
    .src_pop   (pop),
    .line_bit  (line_bit),
    .idle      (ser_idle)
  );

  assign txd      = cfg_break ? 1'b0 : line_bit;
  assign in_ready = !fifo_full;
  assign tx_rdy   = !fifo_full;
  assign tx_empty = fifo_empty && ser_idle;

endmodule

// File: rtl/uart_tx_core_chk.sv
module uart_tx_core_chk #(
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_break,
  input logic             in_valid,
  input logic             in_ready,
  input logic             txd,
  input logic [CNT_W-1:0] fifo_count,
  input logic             fifo_empty,
  input logic             fifo_full,
  input logic             tx_empty,
  input logic             tx_rdy
);

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNT_W'(DEPTH)); // R6

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fifo_count == $past(fifo_count)) ||
             (fifo_count == CNT_W'($past(fifo_count) + 1'b1)) ||
             (fifo_count == CNT_W'($past(fifo_count) - 1'b1))); // R6

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && in_valid) |=> fifo_count <= $past(fifo_count)); // R6

  AST_RDY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == CNT_W'(DEPTH)) |-> (!tx_rdy && !in_ready)); // R7

  AST_EMPTY_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (fifo_empty && fifo_count == '0)); // R8

  AST_EMPTY_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !in_valid) |=> tx_empty); // R8

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !cfg_break) |-> txd); // R1

  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_break |-> !txd); // R9

endmodule

bind uart_tx_core uart_tx_core_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_break  (cfg_break),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .txd        (txd),
  .fifo_count (fifo_count),
  .fifo_empty (fifo_empty),
  .fifo_full  (fifo_full),
  .tx_empty   (tx_empty),
  .tx_rdy     (tx_rdy)
);

// File: tb/uart_tx_core_tb.sv
module uart_tx_core_tb;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       baud_tick;
  logic [1:0] cfg_len;
  logic       cfg_par_en, cfg_par_odd, cfg_stop_long, cfg_break;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_ready, txd, fifo_empty, fifo_full, tx_empty, tx_rdy;
  logic [4:0] fifo_count;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart_tx_core u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop_long(cfg_stop_long), .cfg_break(cfg_break),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .txd(txd),
    .fifo_count(fifo_count), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .tx_empty(tx_empty), .tx_rdy(tx_rdy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic set_fmt(input logic [1:0] len, input bit pe, input bit po, input bit sl);
    cfg_len = len; cfg_par_en = pe; cfg_par_odd = po; cfg_stop_long = sl;
  endtask

  // Walks one character pulse by pulse against a computed waveform
  task automatic check_frame(input logic [7:0] d, input logic [1:0] len,
                             input bit pe, input bit po, input bit sl,
                             input bit brk, input bit scramble,
                             input bit exp_empty, input string req);
    int L     = 5 + int'(len);
    int P     = pe ? 1 : 0;
    int stopt = sl ? ((len == 2'd0) ? 24 : 32) : 16;
    int total = 16 * (1 + L + P) + stopt;
    int bad   = 0;
    int bad_i = -1;
    int idx;
    logic exp_b;
    logic bad_a = 1'b0, bad_e = 1'b0;
    logic pre_empty = 1'b0;
    logic [7:0] mask = 8'((1 << L) - 1);
    logic par = (^(d & mask)) ^ po;
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      idx = i / 16;
      if (brk)                   exp_b = 1'b0;
      else if (idx == 0)         exp_b = 1'b0;
      else if (idx <= L)         exp_b = d[idx-1];
      else if (P == 1 && idx == L + 1) exp_b = par;
      else                       exp_b = 1'b1;
      if (txd !== exp_b) begin
        if (bad == 0) begin bad_i = i; bad_a = txd; bad_e = exp_b; end
        bad++;
      end
      if (i == total - 1) pre_empty = tx_empty;
      if (scramble && i == 20) begin
        cfg_len = ~len; cfg_par_en = !pe; cfg_par_odd = !po; cfg_stop_long = !sl;
      end
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
    if (bad != 0)
      $display("  first mismatch at pulse %0d: txd=%0b want=%0b (len=%0d pe=%0b po=%0b sl=%0b)",
               bad_i, bad_a, bad_e, L, pe, po, sl);
    chk(bad == 0, req, "serial waveform mismatching pulses", bad, 0);
    chk(pre_empty == 1'b0 && tx_empty == exp_empty, "R5 R8",
        "tx_empty before/after final stop pulse", {pre_empty, tx_empty}, {1'b0, exp_empty});
    if (scramble) set_fmt(len, pe, po, sl);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL R11 watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; baud_tick = 1'b0; in_valid = 1'b0; in_data = '0;
    cfg_break = 1'b0;
    set_fmt(2'd3, 1'b0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(txd === 1'b1 && tx_empty && fifo_empty && fifo_count == 0 && in_ready && tx_rdy,
        "R1", "reset flags {txd,tx_empty,fifo_empty,in_ready,tx_rdy}",
        {txd, tx_empty, fifo_empty, in_ready, tx_rdy}, 5'b11111);

    // R2 R3 R4 R5 R10: all formats, format disturbed mid-character
    for (int len = 0; len < 4; len++) begin
      for (int par = 0; par < 3; par++) begin
        for (int sl = 0; sl < 2; sl++) begin
          logic [7:0] d = 8'(8'hA5 ^ (len * 77 + par * 29 + sl * 131));
          set_fmt(2'(len), par != 0, par == 2, sl != 0);
          push(d);
          check_frame(d, 2'(len), par != 0, par == 2, sl != 0, 1'b0, 1'b1, 1'b1,
                      "R2 R3 R4 R5 R10");
        end
      end
    end

    // R9: break while idle, during a character, then recovery
    set_fmt(2'd3, 1'b1, 1'b0, 1'b0);
    cfg_break = 1'b1;
    @(negedge clk);
    chk(txd == 1'b0 && tx_empty, "R9", "idle break {txd,tx_empty}", {txd, tx_empty}, 2'b01);
    push(8'h3C);
    check_frame(8'h3C, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R9");
    cfg_break = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R9", "line after break release", txd, 1);
    push(8'h81);
    check_frame(8'h81, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R9");

    // R6 R7: fill past capacity with baud pulses held off
    set_fmt(2'd0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 17; k++) push(8'(k * 13 + 1));
    chk(fifo_count == 16, "R6", "queue count after 17 pushes", fifo_count, 16);
    chk(!in_ready && !tx_rdy && fifo_full, "R7", "{in_ready,tx_rdy,fifo_full} when full",
        {in_ready, tx_rdy, fifo_full}, 3'b001);
    chk(!tx_empty, "R8", "tx_empty with queued data", tx_empty, 0);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'hEE;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    chk(fifo_count == 16, "R6", "push while full ignored, count", fifo_count, 16);

    // R6 R11: drain in order, back-to-back
    for (int k = 0; k < 17; k++) begin
      if (k == 2)
        chk(fifo_count == 15 && tx_rdy && in_ready, "R7", "room after one pop {count}",
            fifo_count, 15);
      check_frame(8'(k * 13 + 1), 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, k == 16,
                  "R6 R11");
    end
    @(negedge clk);
    chk(tx_empty && fifo_empty && txd, "R8", "final idle {tx_empty,fifo_empty,txd}",
        {tx_empty, fifo_empty, txd}, 3'b111);

    finished = 1;
    summary();
    $finish;
  end

endmodule